// File: doc/BRIEF.md
# Tick-Driven Interval and Watchdog Timer Unit

This block gives an embedded core three timers that all advance on a shared tick enable, usually the time-base strobe. The first is a loadable down-counter that can re-arm itself, the second fires at one of four power-of-two intervals, and the third is a watchdog that escalates in stages. If software never services the watchdog, its last stage raises a two-bit reset request.

Software reaches the unit through one write port and one read port. A two-bit select picks the control word (00), the status word (01) or the down-counter (10). Select 11 reads as zero and ignores writes. Status flags are cleared by writing ones to them. Each of the three interrupt lines is high while its status flag and its enable bit are both set.

The two periodic timers take their timing from a single free-running tick counter that starts at zero on reset. Each period is a power of two, given as a base exponent plus a step per select code, and these exponents are parameters.

Top module: `emb_tick_timers`

## Requirements
- R1: After reset the control word, the status word and the down-counter all read 0, and every interrupt and the reset request are low.
- R2: Only control bits 31:22 are stored. Reading the control word returns those bits and zeros everywhere else. Bits 31:30 select the watchdog period, 29:28 the reset action, 27 the watchdog interrupt enable, 26 the down-counter interrupt enable, 25:24 the interval period, 23 the interval interrupt enable, and 22 auto-reload.
- R3: Only status bits 31:26 exist; all other status bits read 0. Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. If a timer sets a flag in the same cycle that software clears it, the set wins.
- R4: The interval flag (status bit 26) is set on each tick that completes a whole multiple of 2^(FIT_BASE + FIT_STEP*k) ticks since reset, where k is control bits 25:24.
- R5: Writing a nonzero value to the down-counter loads it and starts the countdown, one count per tick. Writing 0 stops it. Reading it returns the remaining count.
- R6: When a tick arrives while the down-counter holds 1, status bit 27 is set. With control bit 22 high, the counter reloads the last value written; otherwise it goes to 0 and stays there.
- R7: The watchdog expires on each tick that completes a whole multiple of 2^(WD_BASE + WD_STEP*k) ticks since reset, where k is control bits 31:30.
- R8: When the watchdog expires with status bit 31 clear, bit 31 is set. When it expires with bit 31 set and bit 30 clear, bit 30 is set.
- R9: When the watchdog expires with status bits 31:30 both set, control bits 29:28 are copied into status bits 29:28. If that value is nonzero, it is driven on the reset-request output and held there until reset, and from then on the watchdog takes no further action.
- R10: The watchdog, down-counter and interval interrupts equal status bit 30 AND control bit 27, status bit 27 AND control bit 26, and status bit 26 AND control bit 23 respectively.
- R11: While the tick enable is low, no counter advances and no timer event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 control, 01 status, 10 down-counter |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source, same encoding as wr_sel |
| rd_data | output | 32 | Read data for rd_sel |
| irq_wdt | output | 1 | Watchdog interrupt |
| irq_pit | output | 1 | Down-counter interrupt |
| irq_fit | output | 1 | Interval interrupt |
| rst_req | output | 2 | Reset request, nonzero once the watchdog escalates |

## Verification
The timers are driven with three tick patterns: a tick on every cycle, a tick on every third cycle, and pseudo-random gaps. The steady pattern exposes errors in period length. The sparse and irregular patterns show whether events follow tick counts rather than clock cycles. A window with the tick held low shows that nothing advances without a tick. Watchdog runs end three ways: serviced before escalation, escalated with a zero reset action (the status field is copied but no request is made), and escalated with nonzero actions. Periodic write-one-to-clear writes that land on active flags exercise the set-over-clear priority.

// File: rtl/ett_pkg.sv
package ett_pkg;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_STAT = 2'b01,
      SEL_PIT  = 2'b10,
      SEL_NONE = 2'b11
   } reg_sel_e;

   // control word bits 31:22
   typedef struct packed {
      logic [1:0] wd_per;
      logic [1:0] wd_rst;
      logic       wd_ie;
      logic       pit_ie;
      logic [1:0] fit_per;
      logic       fit_ie;
      logic       pit_ar;
   } ctrl_t;

   // status word bits 31:26
   typedef struct packed {
      logic       wd_next;
      logic       wd_int;
      logic [1:0] wd_rst;
      logic       pit_st;
      logic       fit_st;
   } stat_t;

   localparam int CTRL_LSB = DATA_W - $bits(ctrl_t);
   localparam int STAT_LSB = DATA_W - $bits(stat_t);
endpackage

// File: rtl/ett_period_tap.sv
module ett_period_tap #(
   parameter int TB_W = 29,
   parameter int BASE = 9,
   parameter int STEP = 4
) (
   input  logic [TB_W-1:0] tb,
   input  logic [1:0]      sel,
   input  logic            tick,
   output logic            hit
);
   localparam int TOP_EXP = BASE + 3 * STEP;
   localparam logic [TB_W-1:0] ONES = '1;

   if (BASE < 1 || STEP < 1 || TOP_EXP > TB_W) begin : g_bad_cfg
      $error("ett_period_tap: exponent range does not fit the tick counter");
   end

   logic [TB_W-1:0] masks [4];

   for (genvar g = 0; g < 4; g++) begin : g_mask
      assign masks[g] = ONES >> (TB_W - (BASE + g * STEP));
   end

   // fires on the tick that completes a full period
   assign hit = tick && ((tb & masks[sel]) == masks[sel]);
endmodule

// File: rtl/ett_pit.sv
module ett_pit #(
   parameter int PIT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld,
   input  logic [PIT_W-1:0] ld_val,
   input  logic             auto_rl,
   output logic [PIT_W-1:0] cnt,
   output logic             expire
);
   logic [PIT_W-1:0] reload_q;

   assign expire = tick && (cnt == PIT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         reload_q <= '0;
      end else if (ld) begin
         cnt      <= ld_val;
         reload_q <= ld_val;
      end else if (expire) begin
         cnt <= auto_rl ? reload_q : '0;
      end else if (tick && cnt != '0) begin
         cnt <= cnt - PIT_W'(1);
      end
   end

   assert_pit_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt == $past(ld_val));
   assert_pit_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ld && !auto_rl) |=> cnt == '0);
   assert_pit_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(cnt));
endmodule

// File: rtl/ett_wdog.sv
module ett_wdog (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic       st_next,
   input  logic       st_int,
   input  logic [1:0] rst_ctl,
   output logic       set_next,
   output logic       set_int,
   output logic       load_rst,
   output logic [1:0] rst_req
);
   logic halted_q;
   logic live;

   assign live     = hit && !halted_q;
   assign set_next = live && !st_next;
   assign set_int  = live && st_next && !st_int;
   assign load_rst = live && st_next && st_int;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         rst_req  <= 2'b00;
      end else if (load_rst && rst_ctl != 2'b00) begin
         halted_q <= 1'b1;
         rst_req  <= rst_ctl;
      end
   end

   assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req != 2'b00) |=> $stable(rst_req));
   assert_one_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({set_next, set_int, load_rst}) <= 1);
endmodule

// File: rtl/emb_tick_timers.sv
module emb_tick_timers
   import ett_pkg::*;
#(
   parameter int PIT_W     = 32,
   parameter int FIT_BASE  = 9,
   parameter int FIT_STEP  = 4,
   parameter int WD_BASE   = 17,
   parameter int WD_STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic [1:0]        rd_sel,
   output logic [31:0]       rd_data,
   output logic              irq_wdt,
   output logic              irq_pit,
   output logic              irq_fit,
   output logic [1:0]        rst_req
);
   localparam int FIT_TOP = FIT_BASE + 3 * FIT_STEP;
   localparam int WD_TOP  = WD_BASE + 3 * WD_STEP;
   localparam int TB_W    = (FIT_TOP > WD_TOP) ? FIT_TOP : WD_TOP;

   if (PIT_W < 2 || PIT_W > DATA_W) begin : g_bad_pit
      $error("emb_tick_timers: PIT_W out of range");
   end

   ctrl_t           ctrl_q;
   stat_t           stat_q, stat_d, clr_mask;
   logic [TB_W-1:0] tb_q;
   logic [PIT_W-1:0] pit_cnt;
   logic            wr_ctrl, wr_stat, wr_pit;
   logic            fit_hit, wd_hit, pit_exp;
   logic            wd_set_next, wd_set_int, wd_load_rst;

   assign wr_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   assign wr_stat = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT);
   assign wr_pit  = wr_en && (reg_sel_e'(wr_sel) == SEL_PIT);

   always_ff @(posedge clk) begin
      if (!rst_n)    tb_q <= '0;
      else if (tick) tb_q <= tb_q + TB_W'(1);
   end

   ett_period_tap #(.TB_W(TB_W), .BASE(FIT_BASE), .STEP(FIT_STEP)) u_fit_tap (
      .tb(tb_q), .sel(ctrl_q.fit_per), .tick(tick), .hit(fit_hit));

   ett_period_tap #(.TB_W(TB_W), .BASE(WD_BASE), .STEP(WD_STEP)) u_wd_tap (
      .tb(tb_q), .sel(ctrl_q.wd_per), .tick(tick), .hit(wd_hit));

   ett_pit #(.PIT_W(PIT_W)) u_pit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ld(wr_pit),
      .ld_val(wr_data[PIT_W-1:0]), .auto_rl(ctrl_q.pit_ar),
      .cnt(pit_cnt), .expire(pit_exp));

   ett_wdog u_wdog (
      .clk(clk), .rst_n(rst_n), .hit(wd_hit),
      .st_next(stat_q.wd_next), .st_int(stat_q.wd_int), .rst_ctl(ctrl_q.wd_rst),
      .set_next(wd_set_next), .set_int(wd_set_int), .load_rst(wd_load_rst),
      .rst_req(rst_req));

   assign clr_mask = wr_stat ? stat_t'(wr_data[DATA_W-1:STAT_LSB]) : '0;

   always_comb begin
      stat_d = stat_q & ~clr_mask;
      if (fit_hit)     stat_d.fit_st  = 1'b1;
      if (pit_exp)     stat_d.pit_st  = 1'b1;
      if (wd_set_next) stat_d.wd_next = 1'b1;
      if (wd_set_int)  stat_d.wd_int  = 1'b1;
      if (wd_load_rst) stat_d.wd_rst  = ctrl_q.wd_rst;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
      end else begin
         stat_q <= stat_d;
         if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[DATA_W-1:CTRL_LSB]);
      end
   end

   always_comb begin
      unique case (reg_sel_e'(rd_sel))
         SEL_CTRL: rd_data = {ctrl_q, {CTRL_LSB{1'b0}}};
         SEL_STAT: rd_data = {stat_q, {STAT_LSB{1'b0}}};
         SEL_PIT:  rd_data = DATA_W'(pit_cnt);
         default:  rd_data = '0;
      endcase
   end

   assign irq_wdt = stat_q.wd_int && ctrl_q.wd_ie;
   assign irq_pit = stat_q.pit_st && ctrl_q.pit_ie;
   assign irq_fit = stat_q.fit_st && ctrl_q.fit_ie;

   assert_fit_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fit_hit |=> stat_q.fit_st);
   assert_req_matches_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|rst_req) |-> stat_q.wd_rst == rst_req);
   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((rst_req != 2'b00) && !wr_stat) |=> $stable(stat_q.wd_rst));
   assert_pit_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pit_exp |=> stat_q.pit_st);
endmodule

// File: tb/emb_tick_timers_tb_top.sv
module emb_tick_timers_tb_top;
   localparam int FB = 2, FS = 1, WB = 5, WS = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'b00;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = 2'b00;
   logic [31:0] rd_data;
   logic        irq_wdt, irq_pit, irq_fit;
   logic [1:0]  rst_req;

   always #5 clk = ~clk;

   emb_tick_timers #(.PIT_W(32), .FIT_BASE(FB), .FIT_STEP(FS),
                     .WD_BASE(WB), .WD_STEP(WS)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .irq_wdt(irq_wdt), .irq_pit(irq_pit), .irq_fit(irq_fit), .rst_req(rst_req));

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference model: m_c[k] is control bit 22+k, m_s[k] is status bit 26+k
   bit [9:0]    m_c;
   bit [5:0]    m_s;
   longint      m_tb;
   bit [31:0]   m_cnt, m_rel;
   bit          m_halt;
   bit [1:0]    m_rq;

   always @(posedge clk) begin : ref_model
      int      fe, we;
      bit      fh, wh, ph;
      bit [5:0] ns;
      if (!rst_n) begin
         m_c = '0; m_s = '0; m_tb = 0; m_cnt = '0; m_rel = '0; m_halt = 0; m_rq = '0;
      end else begin
         fe = FB + FS * int'(m_c[3:2]);
         we = WB + WS * int'(m_c[9:8]);
         fh = tick && (((m_tb + 1) % (longint'(1) << fe)) == 0);
         wh = tick && !m_halt && (((m_tb + 1) % (longint'(1) << we)) == 0);
         ph = tick && (m_cnt == 1);
         ns = m_s;
         if (wr_en && wr_sel == 2'b01) ns = ns & ~wr_data[31:26];
         if (fh) ns[0] = 1;
         if (ph) ns[1] = 1;
         if (wh) begin
            if (!m_s[5]) ns[5] = 1;
            else if (!m_s[4]) ns[4] = 1;
            else begin
               ns[3:2] = m_c[7:6];
               if (m_c[7:6] != 0) begin m_halt = 1; m_rq = m_c[7:6]; end
            end
         end
         if (wr_en && wr_sel == 2'b10) begin
            m_cnt = wr_data; m_rel = wr_data;
         end else if (ph) m_cnt = m_c[0] ? m_rel : 0;
         else if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
         if (wr_en && wr_sel == 2'b00) m_c = wr_data[31:22];
         m_s = ns;
         if (tick) m_tb = m_tb + 1;
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin : compare
      if (rst_n && !done) begin
         check("R10 irq_wdt", 32'(irq_wdt), 32'(m_s[4] & m_c[5]));
         check("R10 irq_pit", 32'(irq_pit), 32'(m_s[1] & m_c[4]));
         check("R10 irq_fit", 32'(irq_fit), 32'(m_s[0] & m_c[1]));
         check("R9 rst_req", 32'(rst_req), 32'(m_rq));
         case (rd_sel)
            2'b00: check("R2 control read", rd_data, {m_c, 22'b0});
            2'b01: check("R3 R4 R6 R7 R8 status read", rd_data, {m_s, 26'b0});
            2'b10: check("R5 counter read", rd_data, m_cnt);
            default: check("R2 unused select", rd_data, 32'h0);
         endcase
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wreg(logic [1:0] s, logic [31:0] d);
      wr_en = 1; wr_sel = s; wr_data = d;
      step();
      wr_en = 0;
   endtask

   task automatic probe(string tag, logic [1:0] s, logic [31:0] exp);
      rd_sel = s;
      @(negedge clk);
      check(tag, rd_data, exp);
      step();
   endtask

   task automatic do_reset();
      rst_n = 0; tick = 0; wr_en = 0;
      repeat (3) step();
      rst_n = 1;
   endtask

   // mode 0: every cycle, 1: every third cycle, 2: pseudo-random
   task automatic run(int n, int mode, int clr_every, logic [31:0] clr_val, int clr_until);
      bit [15:0] lf = 16'hACE1;
      for (int i = 0; i < n; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case (mode)
            0: tick = 1;
            1: tick = (i % 3 == 2);
            default: tick = lf[0];
         endcase
         rd_sel = 2'(i % 4);
         if (clr_every > 0 && i < clr_until && (i % clr_every) == clr_every - 1) begin
            wr_en = 1; wr_sel = 2'b01; wr_data = clr_val;
         end else wr_en = 0;
         step();
      end
      wr_en = 0; tick = 0;
   endtask

   initial begin : watchdog
      #(10 * 200000);
      if (!done) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      #2;
      do_reset();
      // R1 reset state
      probe("R1 control after reset", 2'b00, 32'h0);
      probe("R1 status after reset", 2'b01, 32'h0);
      probe("R1 counter after reset", 2'b10, 32'h0);
      check("R1 outputs after reset", {26'b0, irq_wdt, irq_pit, irq_fit, 1'b0, rst_req}, 32'h0);
      // R11 no tick, nothing moves
      wreg(2'b10, 32'd7);
      repeat (20) step();
      probe("R11 counter frozen without tick", 2'b10, 32'd7);
      // R2 writable control bits, R3 clear with nothing set
      wreg(2'b00, 32'hFFFF_FFFF);
      probe("R2 control mask", 2'b00, 32'hFFC0_0000);
      wreg(2'b01, 32'hFFFF_FFFF);
      probe("R3 status after clear", 2'b01, 32'h0);
      // R5 countdown by ticks
      wreg(2'b10, 32'd6);
      tick = 1; step(); step(); tick = 0;
      probe("R5 remaining after two ticks", 2'b10, 32'd4);
      wreg(2'b10, 32'd0);
      tick = 1; repeat (5) step(); tick = 0;
      probe("R5 stopped after zero write", 2'b10, 32'd0);

      // run 1: reset action 2, auto-reload, steady ticks
      do_reset();
      wreg(2'b00, 32'h2FC0_0000);
      wreg(2'b10, 32'd5);
      run(200, 0, 40, 32'h0C00_0000, 200);
      probe("R9 request with action 2", 2'b01, {6'b111000, 26'b0} | (m_s[1:0] << 26));
      check("R9 rst_req value 2", 32'(rst_req), 32'd2);

      // run 2: action 0, one-shot counter, random ticks, watchdog serviced then left
      do_reset();
      wreg(2'b00, 32'h4FC0_0000 & ~32'h0040_0000);
      wreg(2'b10, 32'd10);
      run(300, 2, 50, 32'hCC00_0000, 300);
      wreg(2'b10, 32'd9);
      run(900, 2, 0, 32'h0, 0);
      check("R9 no request with action 0", 32'(rst_req), 32'd0);

      // run 3: action 3, sparse ticks, interval select 3
      do_reset();
      wreg(2'b00, 32'h3FC0_0000);
      wreg(2'b10, 32'd4);
      run(420, 1, 60, 32'h0C00_0000, 420);
      check("R9 rst_req value 3", 32'(rst_req), 32'd3);
      run(100, 0, 0, 32'h0, 0);
      check("R9 request held", 32'(rst_req), 32'd3);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule